// File: doc/BRIEF.md
# Offset-Biased Program Counter

This block holds the program address of a small pipelined 8-bit processor. Every clock cycle the instruction sequencer hands it a one-bit operation select, an 8-bit offset and a 16-bit absolute address. In step mode the counter adds the offset, read as a two's complement value, and then subtracts a fixed bias of two. In load mode it takes the absolute address as is. The bias means that an offset of two keeps the counter where it is and an offset of three moves it on by one byte.

Because the memory path is pipelined, the counter usually runs a few bytes ahead of the instruction being executed. Small offsets below the bias undo those prefetches. An offset of zero steps back two places, which is what a break needs. An offset of all ones steps back three places, so that an interrupt returns to the instruction that would have run next. The package names all four of these constants so that the sequencer can use them. After reset the counter starts from a parameter address.

Top module: `pc_bias_ctr`

## Requirements
- R1: While the synchronous active-low reset is asserted, pc takes the value START_ADDR (default 16'h0000) at every rising clock edge.
- R2: When op_sel is 0 (step), the next pc equals pc + sign-extended offset - 2, and arithmetic for positive offsets works as expected (offset 8'h7F adds 125).
- R3: The offset is sign-extended by copying bit 7 into bits 15 to 8, so offset 8'h80 takes 130 from pc.
- R4: A step with offset 8'h02 leaves pc unchanged.
- R5: A step with offset 8'h03 moves pc forward by one.
- R6: A step with offset 8'h00 moves pc back by two.
- R7: A step with offset 8'hFF moves pc back by three.
- R8: When op_sel is 1 (load), the next pc equals load_addr, and the offset has no effect on the result.
- R9: All arithmetic wraps modulo 2^16: stepping forward past 16'hFFFF lands on 16'h0000 and onward, and stepping back from low addresses lands near 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 1 | 0 = step by biased offset, 1 = load absolute address |
| offset | input | 8 | Two's complement step offset before the bias |
| load_addr | input | 16 | Absolute address used in load mode |
| pc | output | 16 | Current program counter |

## Verification
The assertions take for granted that op_sel, offset and load_addr are always driven to known values once reset is released. They also assume that each update can be compared with the inputs of the cycle before it, which is why the checks are armed one cycle after reset ends. The bench drives every input on the falling edge, keeps every input defined at all times, and checks pc on the following falling edge. This keeps every relation the assertions check inside the conditions they assume.

// File: rtl/pc_bias_pkg.sv
package pc_bias_pkg;

   typedef enum logic {
      PC_OP_STEP = 1'b0,
      PC_OP_LOAD = 1'b1
   } pc_op_e;

   // Raw offsets seen by the counter, before the bias is removed
   localparam logic [7:0] PC_OFS_HOLD  = 8'h02;
   localparam logic [7:0] PC_OFS_NEXT  = 8'h03;
   localparam logic [7:0] PC_OFS_BACK2 = 8'h00;
   localparam logic [7:0] PC_OFS_BACK3 = 8'hFF;

endpackage

// File: rtl/pc_ofs_sext.sv
module pc_ofs_sext #(
   parameter int OFS_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic [OFS_W-1:0]  ofs_in,
   output logic [ADDR_W-1:0] ofs_ext
);
   localparam int EXT_W = ADDR_W - OFS_W;

   initial begin
      if (OFS_W < 2 || OFS_W >= ADDR_W)
         $error("pc_ofs_sext: OFS_W must be in 2..ADDR_W-1");
   end

   assign ofs_ext[OFS_W-1:0] = ofs_in;

   for (genvar g = 0; g < EXT_W; g++) begin : g_sign
      assign ofs_ext[OFS_W+g] = ofs_in[OFS_W-1];
   end
endmodule

// File: rtl/pc_step_add.sv
module pc_step_add #(
   parameter int ADDR_W = 16,
   parameter int BIAS   = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] delta,
   output logic [ADDR_W-1:0] sum
);
   localparam logic [ADDR_W-1:0] BIAS_V = ADDR_W'(BIAS);

   always_comb begin
      sum = base + delta - BIAS_V;
   end
endmodule

// File: rtl/pc_bias_ctr.sv
module pc_bias_ctr
   import pc_bias_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter int              OFS_W      = 8,
   parameter int              BIAS       = 2,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_sel,
   input  logic [OFS_W-1:0]  offset,
   input  logic [ADDR_W-1:0] load_addr,
   output logic [ADDR_W-1:0] pc
);
   localparam int OFS_MAX = (1 << (OFS_W - 1)) - 1;

   initial begin
      if (BIAS < 0 || BIAS > OFS_MAX)
         $error("pc_bias_ctr: BIAS must fit a positive offset");
   end

   logic [ADDR_W-1:0] ext_ofs;
   logic [ADDR_W-1:0] step_val;
   logic [ADDR_W-1:0] pc_nxt;

   pc_ofs_sext #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_sext (
      .ofs_in  (offset),
      .ofs_ext (ext_ofs)
   );

   pc_step_add #(.ADDR_W(ADDR_W), .BIAS(BIAS)) u_add (
      .base  (pc),
      .delta (ext_ofs),
      .sum   (step_val)
   );

   always_comb begin
      if (pc_op_e'(op_sel) == PC_OP_LOAD) pc_nxt = load_addr;
      else                                pc_nxt = step_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc <= START_ADDR;
      else        pc <= pc_nxt;
   end
endmodule

// File: rtl/pc_bias_chk.sv
module pc_bias_chk #(
   parameter int                ADDR_W     = 16,
   parameter int                OFS_W      = 8,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_sel,
   input logic [OFS_W-1:0]  offset,
   input logic [ADDR_W-1:0] load_addr,
   input logic [ADDR_W-1:0] pc
);
   logic armed;
   logic in_rst;

   always_ff @(posedge clk) begin
      armed  <= rst_n;
      in_rst <= !rst_n;
   end

   // R1
   rst_start_chk: assert property (@(posedge clk)
      (in_rst === 1'b1 && !rst_n) |-> pc == START_ADDR);

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1 && $past(op_sel) == 1'b0 && $past(offset) == 8'h02) |-> $stable(pc));

   // R5
   next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1 && $past(op_sel) == 1'b0 && $past(offset) == 8'h03) |-> pc == ADDR_W'($past(pc) + 1));

   // R6
   back2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1 && $past(op_sel) == 1'b0 && $past(offset) == 8'h00) |-> pc == ADDR_W'($past(pc) - 2));

   // R7
   back3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1 && $past(op_sel) == 1'b0 && $past(offset) == 8'hFF) |-> pc == ADDR_W'($past(pc) - 3));

   // R8
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1 && $past(op_sel) == 1'b1) |-> pc == $past(load_addr));
endmodule

bind pc_bias_ctr pc_bias_chk #(
   .ADDR_W(ADDR_W), .OFS_W(OFS_W), .START_ADDR(START_ADDR)
) u_pc_bias_chk (
   .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .offset(offset),
   .load_addr(load_addr), .pc(pc)
);

// File: tb/pc_bias_ctr_bench.sv
module pc_bias_ctr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_sel = 1'b0;
   logic [7:0]  offset = 8'h02;
   logic [15:0] load_addr = 16'h0000;
   logic [15:0] pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pc_bias_ctr u_pc_bias_ctr (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .offset(offset),
      .load_addr(load_addr), .pc(pc)
   );

   // {op_sel, offset, load_addr, expected pc after the edge, requirement no.}
   localparam int NV = 12;
   localparam logic [48:0] VEC [NV] = '{
      {1'b0, 8'h02, 16'hAAAA, 16'h0000, 8'd4},  // R4 hold
      {1'b0, 8'h03, 16'h5555, 16'h0001, 8'd5},  // R5 next
      {1'b1, 8'h55, 16'h1234, 16'h1234, 8'd8},  // R8 load
      {1'b0, 8'h7F, 16'h0000, 16'h12B1, 8'd2},  // R2 +125
      {1'b0, 8'h80, 16'h0000, 16'h122F, 8'd3},  // R3 -130
      {1'b0, 8'h00, 16'h0000, 16'h122D, 8'd6},  // R6 back two
      {1'b0, 8'hFF, 16'h0000, 16'h122A, 8'd7},  // R7 back three
      {1'b1, 8'h80, 16'hFFFF, 16'hFFFF, 8'd8},  // R8 load, offset ignored
      {1'b0, 8'h03, 16'h0000, 16'h0000, 8'd9},  // R9 wrap forward
      {1'b0, 8'hFF, 16'h0000, 16'hFFFD, 8'd9},  // R9 wrap back
      {1'b0, 8'h05, 16'h0000, 16'h0000, 8'd9},  // R9 wrap forward by 3
      {1'b0, 8'h10, 16'h0000, 16'h000E, 8'd2}   // R2 +14
   };

   task automatic check(input logic [15:0] exp, input int req);
      checks++;
      if (pc !== exp) begin
         errors++;
         $display("FAIL R%0d pc=%h expected=%h", req, pc, exp);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      @(negedge clk);
      check(16'h0000, 1);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         op_sel    = VEC[i][48];
         offset    = VEC[i][47:40];
         load_addr = VEC[i][39:24];
         @(negedge clk);
         check(VEC[i][23:8], int'(VEC[i][7:0]));
      end

      // R4: hold over several cycles
      op_sel = 1'b1; load_addr = 16'h4321; offset = 8'h00;
      @(negedge clk);
      check(16'h4321, 8);
      op_sel = 1'b0; offset = 8'h02; load_addr = 16'h9999;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(16'h4321, 4);
      end

      // R1: reset in mid-run wins over a load
      op_sel = 1'b1; load_addr = 16'hBEEF; rst_n = 1'b0;
      @(negedge clk);
      check(16'h0000, 1);
      rst_n = 1'b1; op_sel = 1'b0; offset = 8'h00;
      // R9: back two from zero
      @(negedge clk);
      check(16'hFFFE, 9);
      // R6 then R7 chained
      @(negedge clk);
      check(16'hFFFC, 6);
      offset = 8'hFF;
      @(negedge clk);
      check(16'hFFF9, 7);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule